// File: doc/BRIEF.md
# Triggered Pin Input Sampler

The block records the level of one asynchronous input pin into a 32-entry, one-bit-wide buffer. The pin first passes a two-stage synchronizer. While sampling is active, the block stores one sample per clock cycle. If trigger mode is selected, it stores a sample only in the cycles where an external trigger pulse is high. Software reads the stored samples oldest first through a show-ahead read port. Empty and full flags and a fill count are always visible.

The block is configured through a single control write that carries three bits: enable, continuous and trigger-select. There are two fill modes:

- **Single-fill mode:** sampling stops at the cycle the buffer becomes full, and the enable state clears itself.
- **Continuous mode:** sampling never stops. Once the buffer is full, each new sample evicts the oldest one, and a sticky overflow flag is set.

Writing the enable bit as 0 stops sampling and empties the buffer. It also clears the overflow flag.

Top module: `pin_sampler`

## Requirements
- R1: After reset:
  - the buffer is empty (`empty_o`=1, `full_o`=0, `count_o`=0);
  - sampling is inactive (`active_o`=0);
  - `overflow_o` is 0.
- R2: A control write (`ctl_we_i`=1) with `ctl_en_i`=1 sets `active_o` at the next clock edge. Sampling begins from the following edge.
- R3: Samples are stored as the synchronized pin level. The synchronizer delays the pin by two clock cycles. Samples are read out oldest first on `rd_data_o`, and `rd_i` pops the current head.
- R4: With trigger-select set (`ctl_trig_sel_i`=1), a sample is stored only in a cycle where `trig_i` is 1. No sample is stored while `trig_i` is 0.
- R5: In single-fill mode (`ctl_cont_i`=0), sampling stops when the count reaches 32, and `active_o` clears itself in the same edge. After that, neither triggers nor clocks add samples.
- R6: In continuous mode (`ctl_cont_i`=1), a sample arriving at a full buffer without a read evicts the oldest sample. The count stays at 32, and `overflow_o` becomes 1 and stays 1.
- R7: A control write with `ctl_en_i`=0 clears `active_o` and empties the buffer (`count_o`=0). It also clears `overflow_o`.
- R8: `rd_i` while the buffer is empty has no effect. A read and a sample in the same cycle leave the count unchanged.
- R9: `count_o` never exceeds 32. `full_o` is 1 exactly when the count is 32, and `empty_o` is 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_en_i | input | 1 | Enable value written |
| ctl_cont_i | input | 1 | Continuous mode value written |
| ctl_trig_sel_i | input | 1 | Trigger-select value written |
| trig_i | input | 1 | Synchronous trigger pulse |
| pin_i | input | 1 | Asynchronous pin input |
| rd_i | input | 1 | Pop the oldest sample |
| rd_data_o | output | 1 | Oldest stored sample |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| count_o | output | 6 | Number of stored samples |
| overflow_o | output | 1 | Sticky eviction flag |
| active_o | output | 1 | Sampling active |

## Verification
The bench uses four stimulus patterns:

- **Irregular bit pattern under trigger mode:** read back oldest first, this separates correct ordering and synchronizer delay from stuck, reversed or shifted storage.
- **Constant-high pin in per-clock single-fill mode:** this shows that the block stops exactly at 32 and self-clears, instead of wrapping or continuing.
- **More than 32 triggered samples in continuous mode:** reading the result back shows which four samples were evicted, and that overflow is flagged.
- **Empty reads, and a read combined with a trigger:** these separate correct count arithmetic from double counting.

// File: rtl/pin_sampler_pkg.sv
package pin_sampler_pkg;
  typedef struct packed {
    logic en;
    logic cont;
    logic trig_sel;
  } ps_cfg_t;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ps_fifo.sv
module ps_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          din_i,
  input  logic          rd_i,
  output logic          dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o,
  output logic          will_full_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q;
  logic             rd_eff, evict;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign rd_eff  = rd_i && !empty_o;
  assign evict   = push_i && full_o && !rd_eff;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                                cnt_d = '0;
    else if (push_i && !rd_eff && !full_o)    cnt_d = cnt_q + 1'b1;
    else if (!push_i && rd_eff)               cnt_d = cnt_q - 1'b1;
  end

  assign will_full_o = !clr_i && (cnt_d == FULL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      mem_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (push_i) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= wptr_q + 1'b1;
      end
      if (rd_eff || evict) rptr_q <= rptr_q + 1'b1;
      if (evict) ovf_q <= 1'b1;
    end
  end

  assign dout_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R9
  AST_EMPTY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_i && !push_i && !clr_i) |=> empty_o); // R8
  AST_EVICT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict && !clr_i) |=> (full_o && ovf_q)); // R6
endmodule

// File: rtl/ps_ctrl.sv
module ps_ctrl
  import pin_sampler_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  ps_cfg_t wcfg_i,
  input  logic trig_i,
  input  logic will_full_i,
  output logic push_o,
  output logic clr_o,
  output logic active_o,
  output logic cont_o
);
  logic active_q, active_d;
  logic cont_q, cont_d;
  logic tsel_q, tsel_d;

  always_comb begin
    active_d = we_i ? wcfg_i.en       : active_q;
    cont_d   = we_i ? wcfg_i.cont     : cont_q;
    tsel_d   = we_i ? wcfg_i.trig_sel : tsel_q;
    if (active_d && !cont_d && will_full_i) active_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cont_q   <= 1'b0;
      tsel_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cont_q   <= cont_d;
      tsel_q   <= tsel_d;
    end
  end

  assign push_o   = active_q && (tsel_q ? trig_i : 1'b1);
  assign clr_o    = we_i && !wcfg_i.en;
  assign active_o = active_q;
  assign cont_o   = cont_q;

  AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wcfg_i.en && !will_full_i) |=> active_q); // R2
  AST_TRIG_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_q && !trig_i) |-> !push_o); // R4
endmodule

// File: rtl/pin_sampler.sv
module pin_sampler
  import pin_sampler_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          ctl_en_i,
  input  logic          ctl_cont_i,
  input  logic          ctl_trig_sel_i,
  input  logic          trig_i,
  input  logic          pin_i,
  input  logic          rd_i,
  output logic          rd_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic          overflow_o,
  output logic          active_o
);
  ps_cfg_t wcfg;
  logic    pin_s, push, clr, will_full, cont;

  assign wcfg = '{en: ctl_en_i, cont: ctl_cont_i, trig_sel: ctl_trig_sel_i};

  ps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  ps_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctl_we_i),
    .wcfg_i     (wcfg),
    .trig_i     (trig_i),
    .will_full_i(will_full),
    .push_o     (push),
    .clr_o      (clr),
    .active_o   (active_o),
    .cont_o     (cont)
  );

  ps_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .push_i     (push),
    .din_i      (pin_s),
    .rd_i       (rd_i),
    .dout_o     (rd_data_o),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .count_o    (count_o),
    .ovf_o      (overflow_o),
    .will_full_o(will_full)
  );

  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !cont) |-> !active_o); // R5
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && !ctl_en_i) |=> (empty_o && !overflow_o && !active_o)); // R7
  AST_OVF_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(cont)); // R6
  AST_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o)); // R9
endmodule

// File: tb/sim_pin_sampler.sv
module sim_pin_sampler;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, en = 0, cont = 0, tsel = 0, trig = 0, pin = 0, rd = 0;
  logic rdata, empty, full, ovf, active;
  logic [5:0] count;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pin_sampler u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_en_i(en),
    .ctl_cont_i(cont), .ctl_trig_sel_i(tsel), .trig_i(trig), .pin_i(pin),
    .rd_i(rd), .rd_data_o(rdata), .empty_o(empty), .full_o(full),
    .count_o(count), .overflow_o(ovf), .active_o(active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ctl(input logic e, input logic c, input logic t);
    @(negedge clk); we = 1; en = e; cont = c; tsel = t;
    @(negedge clk); we = 0;
  endtask

  task automatic trig_sample(input logic b);
    @(negedge clk); pin = b;
    repeat (3) @(negedge clk);
    trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic pop_check(input logic exp, input string req);
    chk(rdata === exp, req, rdata, exp);
    rd = 1;
    @(negedge clk); rd = 0;
  endtask

  function automatic logic pat(input int i);
    return logic'(((i * 7) >> 2) & 1);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(empty === 1 && full === 0, "R1 flags", {empty, full}, 2);
    chk(count === 0, "R1 count", count, 0);
    chk(active === 0 && ovf === 0, "R1 active/ovf", {active, ovf}, 0);
  endtask

  task automatic t_trig_order();
    ctl(1, 0, 1);
    chk(active === 1, "R2 active after enable", active, 1);
    repeat (5) @(negedge clk);
    chk(count === 0, "R4 no trigger no sample", count, 0);
    for (int i = 0; i < 8; i++) trig_sample(pat(i));
    chk(count === 8, "R4 one sample per trigger", count, 8);
    for (int i = 0; i < 8; i++) pop_check(pat(i), "R3 oldest first");
    chk(empty === 1, "R9 empty after drain", empty, 1);
    rd = 1; @(negedge clk); rd = 0;
    chk(count === 0 && empty === 1, "R8 empty read ignored", count, 0);
    ctl(0, 0, 0);
  endtask

  task automatic t_single_clock();
    @(negedge clk); pin = 1;
    repeat (3) @(negedge clk);
    ctl(1, 0, 0);
    repeat (40) @(negedge clk);
    chk(count === 32 && full === 1, "R5 stops at 32", count, 32);
    chk(active === 0, "R5 self clear", active, 0);
    chk(ovf === 0, "R5 no overflow", ovf, 0);
    trig = 1; @(negedge clk); trig = 0;
    chk(count === 32, "R5 no further samples", count, 32);
    for (int i = 0; i < 32; i++) pop_check(1'b1, "R3 constant level");
    chk(count === 0, "R5 drained", count, 0);
    ctl(0, 0, 0);
  endtask

  task automatic t_continuous();
    ctl(1, 1, 1);
    for (int i = 0; i < 36; i++) trig_sample(pat(i + 3));
    chk(count === 32 && full === 1, "R6 count held at 32", count, 32);
    chk(ovf === 1, "R6 overflow set", ovf, 1);
    chk(active === 1, "R6 still active", active, 1);
    for (int i = 0; i < 4; i++) pop_check(pat(i + 7), "R6 oldest evicted");
    chk(count === 28, "R8 pops counted", count, 28);
    @(negedge clk); pin = 1; repeat (3) @(negedge clk);
    trig = 1; rd = 1; @(negedge clk); trig = 0; rd = 0;
    chk(count === 28, "R8 read plus sample", count, 28);
    chk(ovf === 1, "R6 overflow sticky", ovf, 1);
    ctl(0, 0, 0);
    chk(count === 0 && empty === 1, "R7 flush count", count, 0);
    chk(ovf === 0 && active === 0, "R7 flush ovf/active", {ovf, active}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_trig_order();
    t_single_clock();
    t_continuous();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule